// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor. Each cycle it takes the distributor's pending vector and the priority of every interrupt. It finds the most urgent pending interrupt that is not already being serviced. It then drives one interrupt request line when that candidate passes three gates: the enable bit, the priority threshold and the priority of the handler that is currently running.

Software uses four word registers on a plain 32-bit register bus. One is an enable, one is a priority threshold, one is an acknowledge register that is read-only in effect, and one is a completion register that is written. An acknowledge read claims the chosen interrupt. The block marks that interrupt active, pushes its priority onto a small running-priority stack, and pulses the ID back to the distributor. A completion write of the same ID pops the stack, clears the active mark and pulses the ID to the distributor. Nested handlers therefore see correct preemption.

Top module: `cpu_irq_iface`

## Requirements
- R1: Bit 0 of the enable register (offset 0x0) gates signalling. While it is 0, `irqOut` is low within 2 cycles, and an acknowledge read returns 1023.
- R2: The threshold register (offset 0x4) holds 8 bits and resets to 0x00, which blocks every interrupt. Only an interrupt whose priority value is strictly below the threshold can be signalled or acknowledged.
- R3: Among pending interrupts that are not active, a lower priority value is more urgent. On equal values the lowest interrupt ID wins.
- R4: A read of the acknowledge register (offset 0x8) that qualifies returns the chosen ID in bits 9:0 with bits 31:10 zero. The data is available in the cycle after the read strobe. `ackPulse` is high with `ackId` equal to that ID during the read cycle.
- R5: When nothing qualifies, an acknowledge read returns 1023. It raises no `ackPulse` and changes neither the active set nor the running priority.
- R6: A qualifying acknowledge makes the interrupt active, which removes it from selection. Its priority becomes the running priority. After that, only an interrupt with a strictly lower priority value can be signalled.
- R7: A write to the completion register (offset 0xC) whose value equals the ID of the most recently acknowledged active interrupt does three things: it pops the running priority, clears that interrupt's active mark, and pulses `eoiPulse` with `eoiId` equal to the ID. Any other value is ignored. This includes values that have nonzero bits 31:10.
- R8: `irqOut` reflects any change of pending bits, priorities, threshold, enable or running priority within 2 clock cycles.
- R9: If the chosen interrupt stops being pending in the same cycle as the acknowledge read, the read returns 1023 and nothing becomes active. Otherwise the ID returned is exactly the interrupt made active.
- R10: The running-priority stack holds DEPTH levels (default 4). While it is full, `irqOut` stays low and acknowledge reads return 1023.
- R11: Reads of the enable and threshold registers return their stored values, zero-extended. A read of the completion register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pendVec | input | NUM_IRQ | Pending bit per interrupt from the distributor |
| prioFlat | input | NUM_IRQ*PRIO_W | Priority of each interrupt, interrupt i at bits i*PRIO_W upward |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered, valid the cycle after regRd |
| irqOut | output | 1 | Interrupt request to the processor |
| ackPulse | output | 1 | Acknowledge event to the distributor |
| ackId | output | 10 | ID carried with ackPulse |
| eoiPulse | output | 1 | Completion event to the distributor |
| eoiId | output | 10 | ID carried with eoiPulse |

## Verification
The assertions assume that the bus never asserts a read and a write in the same cycle. They also assume the register strobes are single-cycle, and that `pendVec` and `prioFlat` are stable with respect to the clock. The bench issues one bus operation per task call with separated strobes. It changes pending bits and priorities only between operations, and then waits two cycles before judging `irqOut` or acknowledge results against its model. The one deliberate exception is the R9 case, where a pending bit drops in the same cycle as the read.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic [3:0] OFS_ENABLE = 4'h0;
  localparam logic [3:0] OFS_THRESH = 4'h4;
  localparam logic [3:0] OFS_CLAIM  = 4'h8;
  localparam logic [3:0] OFS_FINISH = 4'hC;

  typedef enum logic [1:0] {
    RD_ENABLE = 2'd0,
    RD_THRESH = 2'd1,
    RD_CLAIM  = 2'd2,
    RD_FINISH = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrThresh;
    logic   take;
    logic   done;
    logic   rdLatch;
    rdSel_e rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        candVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  output logic                      bestValid,
  output logic [IDX_W-1:0]          bestIdx,
  output logic [PRIO_W-1:0]         bestPrio
);
  logic              nValid;
  logic [IDX_W-1:0]  nIdx;
  logic [PRIO_W-1:0] nPrio;

  // Scan from the top ID down; "<=" lets a lower ID take over an equal priority.
  always_comb begin
    nValid = 1'b0;
    nIdx   = '0;
    nPrio  = '1;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (candVec[i] && (!nValid || prioFlat[i*PRIO_W +: PRIO_W] <= nPrio)) begin
        nValid = 1'b1;
        nIdx   = IDX_W'(i);
        nPrio  = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bestValid <= 1'b0;
      bestIdx   <= '0;
      bestPrio  <= '1;
    end else begin
      bestValid <= nValid;
      bestIdx   <= nIdx;
      bestPrio  <= nPrio;
    end
  end

  // R3: a registered winner was a candidate in the previous cycle
  p_pick_was_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && bestValid |-> $past(candVec) != '0);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import cpu_irq_pkg::*;
(
  input  logic        regRd,
  input  logic        regWr,
  input  logic [3:0]  regAddr,
  input  logic        takeOk,
  input  logic        doneOk,
  output ctlStrobes_t strb
);
  logic wrOnly;

  assign wrOnly = regWr && !regRd;

  always_comb begin
    strb          = '0;
    strb.rdLatch  = regRd;
    strb.rdSel    = rdSel_e'(regAddr[3:2]);
    strb.wrEnable = wrOnly && (regAddr == OFS_ENABLE);
    strb.wrThresh = wrOnly && (regAddr == OFS_THRESH);
    strb.take     = regRd  && (regAddr == OFS_CLAIM) && takeOk;
    strb.done     = wrOnly && (regAddr == OFS_FINISH) && doneOk;
  end
endmodule

// File: rtl/irq_dp.sv
module irq_dp
  import cpu_irq_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int DEPTH   = 4,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        strb,
  input  logic [31:0]        wrData,
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic               bestValid,
  input  logic [IDX_W-1:0]   bestIdx,
  input  logic [PRIO_W-1:0]  bestPrio,
  output logic [NUM_IRQ-1:0] candVec,
  output logic               takeOk,
  output logic               doneOk,
  output logic               irqOut,
  output logic [31:0]        rdData,
  output logic [ID_W-1:0]    ackId,
  output logic [ID_W-1:0]    eoiId
);
  localparam logic [DW-1:0] DEPTH_V = DW'(DEPTH);

  logic               ctrlEn;
  logic [PRIO_W-1:0]  threshQ;
  logic [NUM_IRQ-1:0] activeVec;
  logic [PRIO_W-1:0]  stkPrio [DEPTH];
  logic [IDX_W-1:0]   stkId   [DEPTH];
  logic [DW-1:0]      depth;
  logic [DW-1:0]      topSlot;
  logic               stackEmpty, stackFull;
  logic [PRIO_W-1:0]  topPrio;
  logic [IDX_W-1:0]   topId;
  logic               preemptOk, passOk;

  assign stackEmpty = (depth == '0);
  assign stackFull  = (depth == DEPTH_V);
  assign topSlot    = stackEmpty ? '0 : depth - 1'b1;
  assign topPrio    = stkPrio[topSlot];
  assign topId      = stkId[topSlot];

  assign candVec   = pendVec & ~activeVec;
  assign preemptOk = stackEmpty || (bestPrio < topPrio);
  assign passOk    = ctrlEn && bestValid && (bestPrio < threshQ) && preemptOk && !stackFull;
  // Re-check the live pending bit so the returned ID is the one that goes active.
  assign takeOk    = passOk && pendVec[bestIdx] && !activeVec[bestIdx];
  assign doneOk    = !stackEmpty && (wrData[31:ID_W] == '0) && (wrData[ID_W-1:0] == ID_W'(topId));

  assign ackId = takeOk ? ID_W'(bestIdx) : SPURIOUS_ID;
  assign eoiId = wrData[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlEn    <= 1'b0;
      threshQ   <= '0;
      activeVec <= '0;
      depth     <= '0;
      irqOut    <= 1'b0;
      rdData    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stkPrio[i] <= '0;
        stkId[i]   <= '0;
      end
    end else begin
      irqOut <= passOk;
      if (strb.wrEnable) ctrlEn  <= wrData[0];
      if (strb.wrThresh) threshQ <= wrData[PRIO_W-1:0];
      if (strb.take) begin
        activeVec[bestIdx]  <= 1'b1;
        stkPrio[depth[DW-1:0]] <= bestPrio;
        stkId[depth[DW-1:0]]   <= bestIdx;
        depth               <= depth + 1'b1;
      end else if (strb.done) begin
        activeVec[topId] <= 1'b0;
        depth            <= depth - 1'b1;
      end
      if (strb.rdLatch) begin
        unique case (strb.rdSel)
          RD_ENABLE: rdData <= {31'd0, ctrlEn};
          RD_THRESH: rdData <= {{(32-PRIO_W){1'b0}}, threshQ};
          RD_CLAIM:  rdData <= {{(32-ID_W){1'b0}}, ackId};
          default:   rdData <= '0;
        endcase
      end
    end
  end

  p_irq_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEn |=> !irqOut);

  p_take_marks_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.take |=> activeVec[$past(bestIdx)]);

  p_preempt_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.take && !stackEmpty |-> bestPrio < topPrio);

  p_take_below_thresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.take |-> bestPrio < threshQ);

  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.done |=> !activeVec[$past(topId)] && depth == $past(depth) - 1'b1);

  p_spurious_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdLatch && strb.rdSel == RD_CLAIM && !strb.take && !strb.done
      |=> $stable(depth) && $stable(activeVec));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DEPTH_V);

  p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.take, strb.done}));
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int DEPTH   = 4,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic                      regRd,
  input  logic                      regWr,
  input  logic [3:0]                regAddr,
  input  logic [31:0]               regWdata,
  output logic [31:0]               regRdata,
  output logic                      irqOut,
  output logic                      ackPulse,
  output logic [9:0]                ackId,
  output logic                      eoiPulse,
  output logic [9:0]                eoiId
);
  ctlStrobes_t        strb;
  logic [NUM_IRQ-1:0] candVec;
  logic               bestValid;
  logic [IDX_W-1:0]   bestIdx;
  logic [PRIO_W-1:0]  bestPrio;
  logic               takeOk, doneOk;

  irq_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) uPick (
    .clk(clk), .rst_n(rst_n), .candVec(candVec), .prioFlat(prioFlat),
    .bestValid(bestValid), .bestIdx(bestIdx), .bestPrio(bestPrio)
  );

  irq_ctl uCtl (
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
    .takeOk(takeOk), .doneOk(doneOk), .strb(strb)
  );

  irq_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(regWdata), .pendVec(pendVec),
    .bestValid(bestValid), .bestIdx(bestIdx), .bestPrio(bestPrio),
    .candVec(candVec), .takeOk(takeOk), .doneOk(doneOk), .irqOut(irqOut),
    .rdData(regRdata), .ackId(ackId), .eoiId(eoiId)
  );

  assign ackPulse = strb.take;
  assign eoiPulse = strb.done;
endmodule

// File: tb/tb_cpu_irq_iface.sv
`timescale 1ns/1ps
module tb_cpu_irq_iface;
  localparam int NIRQ  = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIRQ-1:0] pendR = '0;
  logic [7:0] prioA [NIRQ];
  logic [NIRQ*8-1:0] prioFlat;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irqOut, ackPulse, eoiPulse;
  logic [9:0] ackId, eoiId;

  int checks = 0, failures = 0;

  bit mEn;
  logic [7:0] mMask;
  logic [NIRQ-1:0] mAct;
  int mDepth;
  logic [7:0] mStkP [DEPTH];
  int mStkI [DEPTH];

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < NIRQ; i++) prioFlat[i*8 +: 8] = prioA[i];

  cpu_irq_iface #(.NUM_IRQ(NIRQ), .PRIO_W(8), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .pendVec(pendR), .prioFlat(prioFlat),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .ackPulse(ackPulse), .ackId(ackId),
    .eoiPulse(eoiPulse), .eoiId(eoiId)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model of the selection rule
  function automatic int pickId();
    int b = -1;
    logic [7:0] bp = '0;
    for (int i = 0; i < NIRQ; i++)
      if (pendR[i] && !mAct[i] && (b < 0 || prioA[i] < bp)) begin b = i; bp = prioA[i]; end
    if (b < 0) return -1;
    if (!mEn || mDepth == DEPTH || !(bp < mMask)) return -1;
    if (mDepth > 0 && !(bp < mStkP[mDepth-1])) return -1;
    return b;
  endfunction

  task automatic doReset();
    rst_n = 1'b0; regRd = 0; regWr = 0;
    mEn = 0; mMask = 0; mAct = '0; mDepth = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 regWr = 0;
    if (a == 4'h0) mEn = d[0];
    if (a == 4'h4) mMask = d[7:0];
  endtask

  task automatic doRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1; regAddr = a;
    @(posedge clk);
    #1 regRd = 0;
    d = regRdata;
  endtask

  task automatic chkIrq(input string req);
    settle();
    check(irqOut == (pickId() >= 0), req, irqOut, pickId() >= 0);
  endtask

  task automatic doAck(input string req, input bit dropIt);
    int exp;
    int expRet;
    bit sawPulse;
    logic [9:0] sawId;
    exp = pickId();
    expRet = exp;
    @(negedge clk);
    regRd = 1; regAddr = 4'h8;
    if (dropIt && exp >= 0) begin pendR[exp] = 1'b0; expRet = -1; end
    #1 sawPulse = ackPulse; sawId = ackId;
    @(posedge clk);
    #1 regRd = 0;
    check(sawPulse == (expRet >= 0), req, sawPulse, expRet >= 0);
    if (expRet >= 0) check(sawId == 10'(expRet), req, sawId, expRet);
    check(regRdata == ((expRet >= 0) ? 32'(expRet) : 32'd1023), req, regRdata,
          (expRet >= 0) ? expRet : 1023);
    if (expRet >= 0) begin
      mAct[expRet] = 1'b1;
      mStkP[mDepth] = prioA[expRet];
      mStkI[mDepth] = expRet;
      mDepth++;
    end
  endtask

  task automatic doEoi(input logic [31:0] v, input string req);
    bit match;
    bit sawPulse;
    logic [9:0] sawId;
    match = (mDepth > 0) && (v == 32'(mStkI[mDepth-1]));
    @(negedge clk);
    regWr = 1; regAddr = 4'hC; regWdata = v;
    #1 sawPulse = eoiPulse; sawId = eoiId;
    @(posedge clk);
    #1 regWr = 0;
    check(sawPulse == match, req, sawPulse, match);
    if (match) begin
      check(sawId == v[9:0], req, sawId, v[9:0]);
      mDepth--;
      mAct[mStkI[mDepth]] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < NIRQ; i++) prioA[i] = 8'h80;
    doReset();
    settle();
    check(irqOut == 1'b0, "R1 reset irq", irqOut, 0);
    doRead(4'h0, d); check(d == 0, "R11 reset enable", d, 0);
    doRead(4'h4, d); check(d == 0, "R2 reset threshold", d, 0);

    // Threshold 0 blocks even when enabled
    doWrite(4'h0, 32'd1);
    pendR[5] = 1; pendR[3] = 1;
    chkIrq("R2 zero threshold blocks");
    doAck("R5 spurious under zero threshold", 0);

    doWrite(4'h4, 32'hF0);
    doRead(4'h4, d); check(d == 32'hF0, "R11 threshold readback", d, 32'hF0);
    doRead(4'h0, d); check(d == 32'd1, "R11 enable readback", d, 1);
    doRead(4'hC, d); check(d == 0, "R11 completion reads zero", d, 0);
    chkIrq("R8 irq rises");
    check(irqOut == 1'b1, "R8 irq high", irqOut, 1);
    doAck("R3 tie goes to lowest id", 0);
    check(mStkI[0] == 3, "R4 id three", mStkI[0], 3);

    // Equal priority cannot preempt the running one
    chkIrq("R6 equal prio no preempt");
    check(irqOut == 1'b0, "R6 irq low", irqOut, 0);
    doAck("R5 spurious while running", 0);
    prioA[7] = 8'h40; pendR[7] = 1;
    chkIrq("R6 urgent preempts");
    check(irqOut == 1'b1, "R6 irq high", irqOut, 1);
    doAck("R6 nested ack", 0);

    doEoi(32'd3, "R7 mismatched completion ignored");
    doEoi(32'h0000_0407, "R7 upper bits nonzero ignored");
    pendR[7] = 0;
    doEoi(32'd7, "R7 matching completion");
    doEoi(32'd3, "R7 outer completion");
    chkIrq("R7 after completion");

    // Priority threshold boundary: prio equal to mask is not signalled
    pendR = '0; pendR[9] = 1; prioA[9] = 8'h30;
    doWrite(4'h4, 32'h30);
    chkIrq("R2 equal to threshold blocked");
    check(irqOut == 0, "R2 equal blocked", irqOut, 0);
    doWrite(4'h4, 32'h31);
    chkIrq("R2 just below threshold");
    check(irqOut == 1, "R2 below passes", irqOut, 1);

    doWrite(4'h0, 32'd0);
    chkIrq("R1 disable drops irq");
    check(irqOut == 0, "R1 irq low when disabled", irqOut, 0);
    doAck("R1 spurious when disabled", 0);
    doWrite(4'h0, 32'd1);
    chkIrq("R1 re-enable");

    // Pending drops in the same cycle as the claim
    doAck("R9 pending drop during claim", 1);
    settle();
    check(mAct == '0, "R9 nothing active", mDepth, 0);
    chkIrq("R9 after drop");

    // Fill the stack
    doReset();
    pendR = '0;
    doWrite(4'h0, 32'd1);
    doWrite(4'h4, 32'hFF);
    for (int k = 0; k <= DEPTH; k++) begin
      prioA[k] = 8'(8'h60 - k * 8'h10);
      pendR[k] = 1;
      settle();
      doAck("R10 nest level", 0);
    end
    check(mDepth == DEPTH, "R10 model full", mDepth, DEPTH);
    chkIrq("R10 full stack blocks irq");
    check(irqOut == 0, "R10 irq low when full", irqOut, 0);
    for (int k = DEPTH - 1; k >= 0; k--) doEoi(32'(k), "R7 unwind");
    settle();

    // Constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      if ($urandom_range(0, 2) == 0) begin
        int j;
        j = $urandom_range(0, NIRQ - 1);
        pendR[j] = $urandom_range(0, 1);
        prioA[j] = 8'($urandom_range(0, 15) * 16);
      end
      chkIrq("R8 random irq");
      op = $urandom_range(0, 99);
      if (op < 40) doAck("R4 random claim", 0);
      else if (op < 70) begin
        if (mDepth > 0 && $urandom_range(0, 3) != 0) doEoi(32'(mStkI[mDepth-1]), "R7 random completion");
        else doEoi(32'($urandom_range(0, NIRQ - 1)), "R7 random completion value");
      end else if (op < 80) begin
        int m;
        m = $urandom_range(0, 2);
        doWrite(4'h4, (m == 0) ? 32'h00 : (m == 1) ? 32'hFF : 32'($urandom_range(0, 255)));
      end else if (op < 85) doWrite(4'h0, 32'($urandom_range(0, 3) != 0));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule